// File: doc/BRIEF.md
# Posted-Write Ordering Gate for Interrupts

This block sits beside the request stream that a DMA engine feeds into a PCIe endpoint. Each packet gets a rolling sequence tag, which goes on the side-band user field of the packet's first beat. When a packet is marked as the last one of a filled buffer, the block stores that packet's tag in a small pending queue. Its interrupt request and its host-visible status update are held back until then.

The endpoint reports committed sequence numbers one at a time. Each report is a one-cycle valid strobe carrying a number. A packet whose number has come back can no longer be overtaken, by an interrupt message or by a completion that reads a status register. The block compares each report with the oldest pending tag. On a match it removes that entry and fires a one-cycle release. The release drives the interrupt request and the status-update strobe together. Issue order alone never triggers a release.

When the queue is full, new end-of-buffer packets are stalled by dropping ready toward the DMA source. Packets that do not end a buffer keep flowing.

Top module: `irq_order_gate`

## Requirements
- R1: While reset is low and in the first cycle after it, `tag_out` is 0, `irq_req` and `stat_upd` are 0, and `src_ready` equals `rq_ready`.
- R2: `tag_out` is the tag for the current first beat. It advances by one (modulo 2^TAG_W, so 15 wraps to 0 at the default 4 bits) only after a cycle in which `pkt_valid`, `pkt_sop` and `src_ready` are all 1. Stalled beats and beats with `pkt_sop` at 0 leave it unchanged.
- R3: An accepted first beat with `pkt_eob` at 1 records its tag as pending. Accepting it raises neither `irq_req` nor `stat_upd`.
- R4: If `seq_vld` is 1 and `seq_num` equals the oldest pending tag, that entry is removed. `irq_req` and `stat_upd` are then both 1 for exactly the following cycle.
- R5: A report whose number differs from the oldest pending tag, or any report while nothing is pending, produces no pulse. The pending entries stay unchanged.
- R6: Pending tags are released strictly oldest first. A report that matches only a younger pending tag produces no pulse.
- R7: With QDEPTH tags pending, a first beat with `pkt_eob` at 1 sees `src_ready` and `rq_valid` at 0 and is not accepted. A first beat with `pkt_eob` at 0 is still accepted. After a release, an end-of-buffer beat is accepted again.
- R8: While `seq_vld` is 0, no pulse appears, whatever value `seq_num` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Beat valid from the DMA source |
| pkt_sop | input | 1 | Beat is the first beat of a packet |
| pkt_eob | input | 1 | Packet is the last one of a buffer (qualified by pkt_sop) |
| src_ready | output | 1 | Ready returned to the DMA source |
| rq_valid | output | 1 | Beat valid forwarded to the endpoint |
| rq_ready | input | 1 | Ready from the endpoint |
| tag_out | output | TAG_W | Sequence tag for the first beat's user field |
| seq_vld | input | 1 | Committed-number report strobe |
| seq_num | input | TAG_W | Committed sequence number |
| irq_req | output | 1 | Interrupt request pulse |
| stat_upd | output | 1 | Status-register update strobe |

## Verification
On every cycle, the assertions check four things: the tag steps by exactly one per accepted first beat, the queue is never pushed when full or popped when empty, a pulse only ever follows a live report, and a full queue always blocks end-of-buffer beats. Several properties can only be shown by the bench's scenarios. These are that a pulse appears for the right tag and not for a mismatched or younger one, that entries survive ignored reports, that wrap-around happens correctly, and that ready comes back after a release.

// File: rtl/iog_pkg.sv
package iog_pkg;

   typedef struct packed {
      logic irq;
      logic stat;
   } iog_evt_t;

   localparam iog_evt_t IOG_EVT_NONE = '{irq: 1'b0, stat: 1'b0};
   localparam iog_evt_t IOG_EVT_FIRE = '{irq: 1'b1, stat: 1'b1};

endpackage

// File: rtl/iog_tag_ctr.sv
module iog_tag_ctr #(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [TAG_W-1:0] tag
);

   initial begin
      if (TAG_W < 1) $error("iog_tag_ctr: TAG_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tag <= '0;
      else if (adv) tag <= tag + 1'b1;
   end

   // R2: one step per accepted first beat, wrapping naturally
   a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> tag == TAG_W'($past(tag) + 1'b1));

   a_r2_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(tag));

endmodule

// File: rtl/iog_tag_fifo.sv
module iog_tag_fifo #(
   parameter int TAG_W = 4,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             pop,
   output logic [TAG_W-1:0] head,
   output logic             empty,
   output logic             full
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2) $error("iog_tag_fifo: DEPTH must be at least 2");
      if (DEPTH > (1 << TAG_W)) $error("iog_tag_fifo: DEPTH exceeds tag space");
   end

   logic [TAG_W-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;

   function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         for (int i = 0; i < DEPTH; i++)
            if (wr_ptr == PW'(i)) mem[i] <= push_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= ptr_next(wr_ptr);
         if (pop)  rd_ptr <= ptr_next(rd_ptr);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   // R7: the ready gating upstream must keep a full queue from being pushed
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R5: the matcher must never remove an entry that is not there
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/iog_release.sv
module iog_release #(
   parameter int TAG_W     = 4,
   parameter bit REG_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_vld,
   input  logic [TAG_W-1:0] seq_num,
   input  logic [TAG_W-1:0] head,
   input  logic             empty,
   output logic             pop,
   output iog_pkg::iog_evt_t evt
);
   import iog_pkg::*;

   assign pop = seq_vld && !empty && (seq_num == head);

   generate
      if (REG_PULSE) begin : g_reg
         iog_evt_t evt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) evt_q <= IOG_EVT_NONE;
            else        evt_q <= pop ? IOG_EVT_FIRE : IOG_EVT_NONE;
         end
         assign evt = evt_q;

         // R4: a pulse is always the echo of a live report
         a_r4_after_report: assert property (@(posedge clk) disable iff (!rst_n)
            evt.irq |-> $past(seq_vld));

         // R8: no report, no pulse in the next cycle
         a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !seq_vld |=> !evt.irq && !evt.stat);
      end else begin : g_comb
         assign evt = pop ? IOG_EVT_FIRE : IOG_EVT_NONE;

         a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !seq_vld |-> !evt.irq && !evt.stat);
      end
   endgenerate

endmodule

// File: rtl/irq_order_gate.sv
module irq_order_gate #(
   parameter int TAG_W     = 4,
   parameter int QDEPTH    = 4,
   parameter bit REG_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic             pkt_sop,
   input  logic             pkt_eob,
   output logic             src_ready,
   output logic             rq_valid,
   input  logic             rq_ready,
   output logic [TAG_W-1:0] tag_out,
   input  logic             seq_vld,
   input  logic [TAG_W-1:0] seq_num,
   output logic             irq_req,
   output logic             stat_upd
);
   import iog_pkg::*;

   initial begin
      if (QDEPTH > (1 << TAG_W)) $error("irq_order_gate: QDEPTH larger than tag space");
   end

   logic             sop_beat, hold, accept, push, pop, q_empty, q_full;
   logic [TAG_W-1:0] tag, q_head;
   iog_evt_t         evt;

   assign sop_beat  = pkt_valid && pkt_sop;
   assign hold      = sop_beat && pkt_eob && q_full;
   assign src_ready = rq_ready && !hold;
   assign rq_valid  = pkt_valid && !hold;
   assign accept    = sop_beat && rq_ready && !hold;
   assign push      = accept && pkt_eob;

   iog_tag_ctr #(.TAG_W(TAG_W)) u_ctr (
      .clk (clk),
      .rst_n (rst_n),
      .adv (accept),
      .tag (tag)
   );

   iog_tag_fifo #(.TAG_W(TAG_W), .DEPTH(QDEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_tag (tag),
      .pop      (pop),
      .head     (q_head),
      .empty    (q_empty),
      .full     (q_full)
   );

   iog_release #(.TAG_W(TAG_W), .REG_PULSE(REG_PULSE)) u_rel (
      .clk     (clk),
      .rst_n   (rst_n),
      .seq_vld (seq_vld),
      .seq_num (seq_num),
      .head    (q_head),
      .empty   (q_empty),
      .pop     (pop),
      .evt     (evt)
   );

   assign tag_out  = tag;
   assign irq_req  = evt.irq;
   assign stat_upd = evt.stat;

   // R7: a full queue stalls end-of-buffer first beats toward both sides
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && pkt_valid && pkt_sop && pkt_eob) |-> (!src_ready && !rq_valid));

   // R4: interrupt and status strobe always travel together
   a_r4_paired: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == stat_upd);

endmodule

// File: tb/sim_irq_order_gate.sv
module sim_irq_order_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_valid = 1'b0, pkt_sop = 1'b0, pkt_eob = 1'b0;
   logic       rq_ready = 1'b1;
   logic       seq_vld = 1'b0;
   logic [3:0] seq_num = '0;
   logic       src_ready, rq_valid, irq_req, stat_upd;
   logic [3:0] tag_out;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_tag = '0;

   always #10 clk = ~clk;

   irq_order_gate u0 (
      .clk (clk), .rst_n (rst_n),
      .pkt_valid (pkt_valid), .pkt_sop (pkt_sop), .pkt_eob (pkt_eob),
      .src_ready (src_ready), .rq_valid (rq_valid), .rq_ready (rq_ready),
      .tag_out (tag_out), .seq_vld (seq_vld), .seq_num (seq_num),
      .irq_req (irq_req), .stat_upd (stat_upd)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // one-beat packet; returns the tag it carried
   task automatic send(input logic eob, output logic [3:0] t);
      @(negedge clk);
      pkt_valid = 1'b1; pkt_sop = 1'b1; pkt_eob = eob;
      #1 chk("R2 tag on first beat", tag_out, exp_tag);
      chk("R7 ready for beat", src_ready, 1);
      t = exp_tag;
      @(negedge clk);
      pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eob = 1'b0;
      exp_tag = exp_tag + 1'b1;
      chk("R2 tag advanced", tag_out, exp_tag);
      chk("R3 no pulse on push", irq_req, 0);
   endtask

   task automatic report(input logic vld, input logic [3:0] n, input int pulse, input string req);
      @(negedge clk);
      seq_vld = vld; seq_num = n;
      @(negedge clk);
      seq_vld = 1'b0;
      chk({req, " irq_req"}, irq_req, pulse);
      chk({req, " stat_upd"}, stat_upd, pulse);
      @(negedge clk);
      chk({req, " pulse one cycle"}, irq_req, 0);
   endtask

   task automatic t_reset();
      chk("R1 tag at reset", tag_out, 0);
      chk("R1 irq at reset", irq_req, 0);
      chk("R1 stat at reset", stat_upd, 0);
      chk("R1 ready follows", src_ready, 1);
      rq_ready = 1'b0;
      #1 chk("R1 ready follows low", src_ready, 0);
      rq_ready = 1'b1;
   endtask

   task automatic t_tags();
      logic [3:0] t;
      for (int i = 0; i < 18; i++) send(1'b0, t);   // crosses 15 -> 0
      // stalled first beat
      @(negedge clk);
      rq_ready = 1'b0; pkt_valid = 1'b1; pkt_sop = 1'b1;
      @(negedge clk);
      chk("R2 stall holds tag", tag_out, exp_tag);
      rq_ready = 1'b1; pkt_sop = 1'b0;
      @(negedge clk);
      chk("R2 non-first beat holds tag", tag_out, exp_tag);
      pkt_valid = 1'b0;
      exp_tag = 4'd15;
      // step to 15 then wrap explicitly
      while (tag_out != 4'd15) begin
         exp_tag = tag_out;
         send(1'b0, t);
      end
      exp_tag = 4'd15;
      send(1'b0, t);
      chk("R2 wrap to zero", tag_out, 0);
   endtask

   task automatic t_release();
      logic [3:0] t;
      send(1'b1, t);
      report(1'b1, t + 4'd3, 0, "R5 mismatch");
      report(1'b0, t, 0, "R8 strobe low");
      report(1'b1, t, 1, "R4 match");
      report(1'b1, t, 0, "R5 nothing pending");
   endtask

   task automatic t_order();
      logic [3:0] a, b, c;
      send(1'b1, a);
      send(1'b1, b);
      send(1'b1, c);
      report(1'b1, b, 0, "R6 younger ignored");
      report(1'b1, a, 1, "R6 oldest first");
      report(1'b1, b, 1, "R6 second");
      report(1'b1, c, 1, "R6 third");
   endtask

   task automatic t_full();
      logic [3:0] p [4];
      logic [3:0] t;
      for (int i = 0; i < 4; i++) send(1'b1, p[i]);
      @(negedge clk);
      pkt_valid = 1'b1; pkt_sop = 1'b1; pkt_eob = 1'b1;
      #1 chk("R7 ready low when full", src_ready, 0);
      chk("R7 valid blocked when full", rq_valid, 0);
      @(negedge clk);
      chk("R7 held beat not accepted", tag_out, exp_tag);
      pkt_eob = 1'b0;
      #1 chk("R7 plain packet ready", src_ready, 1);
      @(negedge clk);
      pkt_valid = 1'b0; pkt_sop = 1'b0;
      exp_tag = exp_tag + 1'b1;
      chk("R7 plain packet accepted", tag_out, exp_tag);
      report(1'b1, p[0], 1, "R7 release while full");
      send(1'b1, t);
      report(1'b1, p[1], 1, "R7 drain");
      report(1'b1, p[2], 1, "R7 drain");
      report(1'b1, p[3], 1, "R7 drain");
      report(1'b1, t, 1, "R7 refilled entry");
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tag after reset", tag_out, 0);
      t_tags();
      t_release();
      t_order();
      t_full();
      finish_run();
   end

endmodule